// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block is the software-facing register front end of an interrupt routing controller with a parameterised number of input pins (24 by default). A bus master reaches every register through two bus offsets. It first writes a register number into a select register. It then reads or writes the selected 32-bit register through a data window.

Behind the window sit a 4-bit controller identifier, a read-only version word, and one 64-bit routing entry per pin. Each routing entry is reached as two 32-bit halves.

All routing entries are presented in parallel to the downstream routing logic. After every accepted write to a table half, a one-cycle strobe carries the pin index, so that the routing logic can re-evaluate that pin. The routing logic can set an entry's remote-pending bit through a per-pin set input. Software cannot set that bit. Writing the entry's low half clears it.

Top module: `irc_regfile`

## Requirements
- R1: Only `bus_addr[7:0]` is decoded; offset 0x00 is the select register, offset 0x10 is the data window, and any other offset reads as 0 and ignores writes.
- R2: A write is accepted only when `bus_size` is 2 (4 bytes) or 3 (8 bytes), using `bus_wdata`; size codes 0 (1 byte) and 1 (2 bytes) are dropped with no effect.
- R3: A read returns its data on `rdata` with `rd_valid` high in the cycle after `bus_rd`; reading offset 0x00 returns the select value.
- R4: Select value 1 reads as {8'h00, PINS-1, 8'h00, VERSION}; writes to it are ignored.
- R5: Select value 0 holds a 4-bit identifier written from and read in bits 27:24. Select value 2 reads the same word and ignores writes. Select values 3 to 15 read as 0.
- R6: For a select value S of 16 or more, the pin index is (S-16)>>1; odd S addresses entry bits 63:32, even S addresses bits 31:0, and a write to one half leaves the other half unchanged.
- R7: When the computed pin index is PINS or more, a window write changes nothing and raises no strobe, and a window read returns 0.
- R8: Entry bit 14 (remote-pending) is set by a pulse on `rpend_set[i]`. A write to the low half clears it, and clearing wins over a set in the same cycle. A high-half write keeps it, and software data never sets it.
- R9: After reset every entry is 64'h0000_0000_0001_0000 (mask bit 16 set), the identifier and select are 0, and `upd_stb` is low.
- R10: An accepted table write raises `upd_stb` for exactly one cycle, in the cycle after the write, with `upd_pin` equal to the pin index.
- R11: Entry i appears on `entries[64*i +: 64]` with field layout vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14, trigger mode 15, mask 16, destination 63:56, updated in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| bus_size | input | 2 | Access size code: 0=1B, 1=2B, 2=4B, 3=8B |
| bus_wdata | input | 32 | Write data (low word of the access) |
| rpend_set | input | PINS | Per-pin set of the remote-pending bit |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read |
| entries | output | PINS*64 | All routing entries, pin i at bits 64*i+63:64*i |
| upd_stb | output | 1 | One-cycle pulse after a table write |
| upd_pin | output | $clog2(PINS) | Pin index for `upd_stb` |

## Verification
Every result in this block is due one register stage after its stimulus. Read data and `rd_valid` appear the cycle after `bus_rd`. A table write shows on `entries`, `upd_stb` and `upd_pin` the cycle after `bus_wr`, and an `rpend_set` pulse shows on bit 14 one cycle later. The bench drives every input on the falling edge and holds it across exactly one rising edge. It samples outputs on the next falling edge, which is the one cycle in which a strobe is visible. Cases that must have no effect are checked by reading back the select, the identifier or the entry through the window, or by observing `upd_stb` low in that same cycle.

// File: rtl/irc_pkg.sv
`timescale 1ns/1ps
package irc_pkg;
  // bus offsets (low address byte)
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  // select values below the table
  localparam int SEL_ID   = 0;
  localparam int SEL_VER  = 1;
  localparam int SEL_ARB  = 2;
  localparam int SEL_TBL0 = 16;

  // entry field positions
  localparam int F_RPEND = 14;
  localparam int F_MASK  = 16;
  localparam int ID_LSB  = 24;
  localparam int ID_W    = 4;

  localparam logic [63:0] ENT_RESET = 64'h1 << F_MASK;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } bus_size_e;

  function automatic logic size_ok(input logic [1:0] sz);
    return (sz == SZ_B4) || (sz == SZ_B8);
  endfunction
endpackage

// File: rtl/irc_ctrl_regs.sv
`timescale 1ns/1ps
module irc_ctrl_regs
  import irc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 8,
  parameter int PINS   = 24,
  parameter int IDX_W  = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ID_W-1:0]   id_q,
  output logic              tbl_hit,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              tbl_we_lo,
  output logic              tbl_we_hi,
  output logic              sel_rd,
  output logic              win_rd
);
  localparam logic [SEL_W-1:0] SEL_TBL_BASE = SEL_W'(SEL_TBL0);
  localparam logic [SEL_W-1:0] PIN_LIMIT    = SEL_W'(PINS);

  logic [7:0]       ofs;
  logic             hit_sel, hit_win, wr_ok;
  logic [SEL_W-1:0] idx_wide;
  logic [ADDR_W-1:0] unused_addr;

  assign unused_addr = bus_addr;
  assign ofs     = bus_addr[7:0];
  assign hit_sel = (ofs == OFS_SEL);
  assign hit_win = (ofs == OFS_WIN);
  assign wr_ok   = bus_wr && size_ok(bus_size);

  assign idx_wide = (sel_q - SEL_TBL_BASE) >> 1;
  assign tbl_hit  = (sel_q >= SEL_TBL_BASE) && (idx_wide < PIN_LIMIT);
  assign tbl_idx  = idx_wide[IDX_W-1:0];

  assign tbl_we_lo = wr_ok && hit_win && tbl_hit && !sel_q[0];
  assign tbl_we_hi = wr_ok && hit_win && tbl_hit &&  sel_q[0];
  assign sel_rd    = bus_rd && hit_sel;
  assign win_rd    = bus_rd && hit_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_ok && hit_sel)
        sel_q <= bus_wdata[SEL_W-1:0];
      if (wr_ok && hit_win && sel_q == SEL_W'(SEL_ID))
        id_q <= bus_wdata[ID_LSB +: ID_W];
    end
  end

  // R1
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit_sel && !hit_win) |=> ($stable(sel_q) && $stable(id_q)));

  // R2
  narrow_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_size == SZ_B1 || bus_size == SZ_B2)) |=> ($stable(sel_q) && $stable(id_q)));

  // R5
  id_ro_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_win && (sel_q == SEL_W'(SEL_ARB) || sel_q == SEL_W'(SEL_VER))) |=> $stable(id_q));
endmodule

// File: rtl/irc_entry_table.sv
`timescale 1ns/1ps
module irc_entry_table
  import irc_pkg::*;
#(
  parameter int PINS  = 24,
  parameter int IDX_W = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [IDX_W-1:0]  idx,
  input  logic [31:0]       wdata,
  input  logic [PINS-1:0]   rpend_set,
  output logic [PINS*64-1:0] entries_flat,
  output logic              upd_stb,
  output logic [IDX_W-1:0]  upd_pin
);
  // software data with the read-only remote-pending bit forced clear
  logic [31:0] lo_data;
  assign lo_data = wdata & ~(32'h1 << F_RPEND);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [63:0] ent_q;
    logic        sel_lo, sel_hi;

    assign sel_lo = we_lo && (idx == IDX_W'(i));
    assign sel_hi = we_hi && (idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= ENT_RESET;
      end else begin
        if (sel_lo)
          ent_q[31:0] <= lo_data;
        else if (rpend_set[i])
          ent_q[F_RPEND] <= 1'b1;
        if (sel_hi)
          ent_q[63:32] <= wdata;
      end
    end

    assign entries_flat[64*i +: 64] = ent_q;

    // R8
    rpend_clear_chk: assert property (@(posedge clk) disable iff (rst)
      sel_lo |=> !ent_q[F_RPEND]);

    // R6
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
      sel_hi |=> ((ent_q[31:0] & ~(32'h1 << F_RPEND)) ==
                  ($past(ent_q[31:0]) & ~(32'h1 << F_RPEND))));

    // R9
    reset_mask_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (ent_q[F_MASK] && !ent_q[F_RPEND]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_stb <= 1'b0;
      upd_pin <= '0;
    end else begin
      upd_stb <= we_lo || we_hi;
      if (we_lo || we_hi)
        upd_pin <= idx;
    end
  end
endmodule

// File: rtl/irc_read_mux.sv
`timescale 1ns/1ps
module irc_read_mux
  import irc_pkg::*;
#(
  parameter int          PINS    = 24,
  parameter int          IDX_W   = $clog2(PINS),
  parameter int          SEL_W   = 8,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_rd,
  input  logic               sel_rd,
  input  logic               win_rd,
  input  logic [SEL_W-1:0]   sel_q,
  input  logic [ID_W-1:0]    id_q,
  input  logic               tbl_hit,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [PINS*64-1:0] entries_flat,
  output logic [31:0]        rdata,
  output logic               rd_valid
);
  localparam logic [7:0]  MAX_PIN  = 8'(PINS - 1);
  localparam logic [31:0] VER_WORD = {8'h00, MAX_PIN, 8'h00, VERSION};

  logic [63:0] ent_sel;
  logic [31:0] word;

  assign ent_sel = entries_flat[64*int'(tbl_idx) +: 64];

  always_comb begin
    word = '0;
    if (sel_rd) begin
      word = 32'(sel_q);
    end else if (win_rd) begin
      if (sel_q == SEL_W'(SEL_ID) || sel_q == SEL_W'(SEL_ARB))
        word = {{(32-ID_LSB-ID_W){1'b0}}, id_q, {ID_LSB{1'b0}}};
      else if (sel_q == SEL_W'(SEL_VER))
        word = VER_WORD;
      else if (tbl_hit)
        word = sel_q[0] ? ent_sel[63:32] : ent_sel[31:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd)
        rdata <= word;
    end
  end
endmodule

// File: rtl/irc_regfile.sv
`timescale 1ns/1ps
module irc_regfile
  import irc_pkg::*;
#(
  parameter int         ADDR_W  = 32,
  parameter int         SEL_W   = 8,
  parameter int         PINS    = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int        IDX_W   = $clog2(PINS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  input  logic [PINS-1:0]    rpend_set,
  output logic [31:0]        rdata,
  output logic               rd_valid,
  output logic [PINS*64-1:0] entries,
  output logic               upd_stb,
  output logic [IDX_W-1:0]   upd_pin
);
  logic [SEL_W-1:0] sel_q;
  logic [ID_W-1:0]  id_q;
  logic             tbl_hit, tbl_we_lo, tbl_we_hi, sel_rd, win_rd;
  logic [IDX_W-1:0] tbl_idx;

  irc_ctrl_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .PINS(PINS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .sel_q(sel_q), .id_q(id_q),
    .tbl_hit(tbl_hit), .tbl_idx(tbl_idx), .tbl_we_lo(tbl_we_lo), .tbl_we_hi(tbl_we_hi),
    .sel_rd(sel_rd), .win_rd(win_rd)
  );

  irc_entry_table #(.PINS(PINS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst), .we_lo(tbl_we_lo), .we_hi(tbl_we_hi), .idx(tbl_idx),
    .wdata(bus_wdata), .rpend_set(rpend_set), .entries_flat(entries),
    .upd_stb(upd_stb), .upd_pin(upd_pin)
  );

  irc_read_mux #(.PINS(PINS), .IDX_W(IDX_W), .SEL_W(SEL_W), .VERSION(VERSION)) u_rmux (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .sel_rd(sel_rd), .win_rd(win_rd),
    .sel_q(sel_q), .id_q(id_q), .tbl_hit(tbl_hit), .tbl_idx(tbl_idx),
    .entries_flat(entries), .rdata(rdata), .rd_valid(rd_valid)
  );

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid);

  // R1
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[7:0] != OFS_SEL && bus_addr[7:0] != OFS_WIN) |=> (rdata == 32'h0));

  // R10
  stb_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    upd_stb |-> ($past(bus_wr) && $past(bus_addr[7:0]) == OFS_WIN));

  // R7
  oob_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_q >= SEL_W'(SEL_TBL0) && ((sel_q - SEL_W'(SEL_TBL0)) >> 1) >= SEL_W'(PINS))
      |=> !upd_stb);
endmodule

// File: tb/test_irc_regfile.sv
`timescale 1ns/1ps
module test_irc_regfile;
  localparam int PINS = 24;
  localparam int IDX_W = $clog2(PINS);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]       bus_addr = '0;
  logic [1:0]        bus_size = 2'd2;
  logic [31:0]       bus_wdata = '0;
  logic [PINS-1:0]   rpend_set = '0;
  logic [31:0]       rdata;
  logic              rd_valid;
  logic [PINS*64-1:0] entries;
  logic              upd_stb;
  logic [IDX_W-1:0]  upd_pin;

  int checks = 0;
  int errors = 0;

  irc_regfile i_irc_regfile (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .rpend_set(rpend_set),
    .rdata(rdata), .rd_valid(rd_valid), .entries(entries),
    .upd_stb(upd_stb), .upd_pin(upd_pin)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write, inputs held across one rising edge; returns at the next falling edge
  task automatic wr(input logic [31:0] addr, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = addr; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 2'd2;
  endtask

  task automatic rd(input logic [31:0] addr, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = addr;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R3 rd_valid", {63'd0, rd_valid}, 64'd1);
    d = rdata;
  endtask

  task automatic win_rd_sel(input logic [7:0] s, output logic [31:0] d);
    wr(32'h0, 2'd2, {24'd0, s});
    rd(32'h10, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 upd_stb", {63'd0, upd_stb}, 64'd0);
    for (int p = 0; p < PINS; p++)
      chk("R9 entry", entries[64*p +: 64], 64'h0000_0000_0001_0000);
    rd(32'h0, d);
    chk("R9 select", {32'd0, d}, 64'd0);
    rd(32'h10, d);
    chk("R9 id", {32'd0, d}, 64'd0);
  endtask

  task automatic t_version();
    logic [31:0] d;
    win_rd_sel(8'h01, d);
    chk("R4 version", {32'd0, d}, 64'h0017_0011);
    wr(32'h10, 2'd2, 32'hFFFF_FFFF);
    chk("R4 no strobe", {63'd0, upd_stb}, 64'd0);
    rd(32'h10, d);
    chk("R4 write ignored", {32'd0, d}, 64'h0017_0011);
  endtask

  task automatic t_id();
    logic [31:0] d;
    wr(32'h0, 2'd2, 32'h0);
    wr(32'h10, 2'd2, 32'hA500_0000);
    rd(32'h10, d);
    chk("R5 id", {32'd0, d}, 64'h0500_0000);
    win_rd_sel(8'h02, d);
    chk("R5 alias read", {32'd0, d}, 64'h0500_0000);
    wr(32'h10, 2'd2, 32'h0F00_0000);
    win_rd_sel(8'h00, d);
    chk("R5 alias write ignored", {32'd0, d}, 64'h0500_0000);
    win_rd_sel(8'h05, d);
    chk("R5 gap reads zero", {32'd0, d}, 64'd0);
  endtask

  task automatic t_table_halves();
    logic [31:0] d;
    wr(32'h0, 2'd2, 32'h16);
    wr(32'h10, 2'd2, 32'h0000_C031);
    chk("R10 strobe", {63'd0, upd_stb}, 64'd1);
    chk("R10 pin", 64'(upd_pin), 64'd3);
    chk("R11 entry3 out", entries[64*3 +: 64], 64'h0000_0000_0000_8031);
    @(negedge clk);
    chk("R10 one cycle", {63'd0, upd_stb}, 64'd0);
    wr(32'h0, 2'd2, 32'h17);
    wr(32'h10, 2'd2, 32'hAB00_0000);
    chk("R11 entry3 hi", entries[64*3 +: 64], 64'hAB00_0000_0000_8031);
    rd(32'h10, d);
    chk("R6 hi read", {32'd0, d}, 64'hAB00_0000);
    win_rd_sel(8'h16, d);
    chk("R6 lo kept", {32'd0, d}, 64'h0000_8031);
  endtask

  task automatic t_rpend();
    logic [31:0] d;
    @(negedge clk);
    rpend_set[3] = 1'b1;
    @(negedge clk);
    rpend_set[3] = 1'b0;
    chk("R8 set", {63'd0, entries[64*3 + 14]}, 64'd1);
    win_rd_sel(8'h16, d);
    chk("R8 set read", {32'd0, d}, 64'h0000_C031);
    wr(32'h0, 2'd2, 32'h17);
    wr(32'h10, 2'd2, 32'hCD00_0000);
    win_rd_sel(8'h16, d);
    chk("R8 hi write keeps", {32'd0, d}, 64'h0000_C031);
    wr(32'h10, 2'd2, 32'h0000_4022);
    rd(32'h10, d);
    chk("R8 lo write clears", {32'd0, d}, 64'h0000_0022);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 32'h10; bus_wdata = 32'h0000_0033; rpend_set[3] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; rpend_set[3] = 1'b0;
    chk("R8 clear wins", entries[64*3 +: 32], 64'h0000_0033);
  endtask

  task automatic t_range();
    logic [31:0] d;
    wr(32'h0, 2'd2, 32'h3E);
    wr(32'h10, 2'd2, 32'h0000_0055);
    chk("R10 last pin", 64'(upd_pin), 64'd23);
    chk("R11 entry23", entries[64*23 +: 64], 64'h0000_0000_0000_0055);
    wr(32'h0, 2'd2, 32'h40);
    wr(32'h10, 2'd2, 32'h0000_1234);
    chk("R7 no strobe", {63'd0, upd_stb}, 64'd0);
    rd(32'h10, d);
    chk("R7 read zero", {32'd0, d}, 64'd0);
    chk("R7 entry23 kept", entries[64*23 +: 64], 64'h0000_0000_0000_0055);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    wr(32'h0, 2'd2, 32'h18);
    wr(32'h0, 2'd0, 32'h3E);
    rd(32'h0, d);
    chk("R2 byte write dropped", {32'd0, d}, 64'h18);
    wr(32'h10, 2'd1, 32'h0000_0099);
    chk("R2 half write no strobe", {63'd0, upd_stb}, 64'd0);
    wr(32'h20, 2'd2, 32'h3E);
    chk("R1 unmapped no strobe", {63'd0, upd_stb}, 64'd0);
    rd(32'h20, d);
    chk("R1 unmapped reads zero", {32'd0, d}, 64'd0);
    rd(32'h0, d);
    chk("R1 select kept", {32'd0, d}, 64'h18);
    wr(32'h1234_5600, 2'd3, 32'h10);
    wr(32'hABCD_EF10, 2'd3, 32'h0000_0045);
    chk("R2 8-byte write", entries[64*0 +: 64], 64'h0000_0000_0000_0045);
    chk("R1 upper bits ignored", 64'(upd_pin), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_version();
    t_id();
    t_table_halves();
    t_rpend();
    t_range();
    t_decode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule